// File: doc/BRIEF.md
# Serial-Link PHY Bring-Up Sequencer

This block takes a high-speed serial-link PHY out of reset. It follows one fixed recipe and produces the register bit images that the PHY's control logic consumes. A single start pulse launches the run from idle. The run proceeds as follows:

1. The reset image is cleared and then built up field by field.
2. Two PHY control bits are adjusted.
3. An external configuration sub-sequencer is handed control through a request/done/error handshake.
4. The calibration bits and the generation-mode field are written.
5. The common-block reset bit is pulsed low for one cycle.

After the pulse, the block samples a PLL-lock input at a fixed interval for a bounded number of samples. It then reports done and a pass/fail verdict. Pass requires both a lock and an error-free configuration phase.

Each image change is registered and held for at least one cycle, so that downstream logic and observers see the steps in order. The lock input is assumed to be synchronous to `clk`. The PHY and the configuration bus are external to the block.

Top module: `phy_bringup_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs are `rst_img_o`=0, `phy_ctl_o`=2'b10 (bit 1 reference-rate set, bit 0 high-speed clear), `cal_o`=0, `gen_o`=0, and `cfg_req_o`, `done_o` and `pass_o` are all 0.
- R2: A high `start_i` seen on a clock edge while idle launches a run and clears `done_o` and `pass_o` on that edge. A `start_i` seen while a run is in progress has no effect on any output.
- R3: On the four successive edges after launch, `rst_img_o` takes the values 0, 0x0003D, 0xF003D and 0xF003F, one per edge, in that order. The last step sets the common-reset bit, which is bit 1.
- R4: On the next edge `phy_ctl_o` bit 1 is cleared. On the edge after that, bit 0 is set.
- R5: On the following edge `cfg_req_o` rises. It stays high until an edge on which `cfg_done_i` or `cfg_err_i` is high, and falls on that edge. If `cfg_err_i` is high on that edge, the configuration phase is recorded as failed.
- R6: On the edge after `cfg_req_o` falls, both bits of `cal_o` (bit 1 select, bit 0 calibrated) become 1 together. On the edge after that, `gen_o` becomes `GEN_CODE`, which defaults to 2, the third generation counted from 0.
- R7: On the next two edges, `rst_img_o` bit 1 goes to 0 and then back to 1. All other bits stay at 0xF003F.
- R8: The first lock sample is taken on the edge after bit 1 returns high. Further samples follow every `POLL_GAP` edges, up to `POLL_LIMIT` samples in all. `done_o` rises on the edge of the first sample that sees `pll_lock_i` high, or on the edge of the last sample if none does.
- R9: When `done_o` rises, `pass_o` is 1 if the lock was seen and the configuration phase did not fail, and 0 otherwise. `done_o` and `pass_o` hold their values until the next launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, honoured only when idle |
| cfg_done_i | input | 1 | Configuration sub-sequencer finished without error |
| cfg_err_i | input | 1 | Configuration sub-sequencer finished with an error |
| pll_lock_i | input | 1 | PLL lock status from the PHY |
| cfg_req_o | output | 1 | Request to the configuration sub-sequencer |
| rst_img_o | output | RST_W | Reset control register image |
| phy_ctl_o | output | 2 | PHY control image: [1] reference rate, [0] high-speed enable |
| cal_o | output | 2 | Calibration image: [1] select, [0] calibrated |
| gen_o | output | GEN_W | Generation-mode field |
| done_o | output | 1 | Run finished, held until next launch |
| pass_o | output | 1 | Run verdict, valid while `done_o` is high |

## Verification
Every image step lands exactly one edge after the previous one. The bench therefore samples on falling edges and compares each observed change of the whole output vector, in order, against a queue of the expected changes. A step that is skipped, reordered or inserted is caught no matter which cycle it falls in.

The handshake steps are due one edge after the stub's done or error level is seen. The lock verdict is due a fixed count after the final common-reset edge: 1 edge when lock is already present, and 1 + (k-1)·`POLL_GAP` edges for the k-th sample. The bench counts falling edges from that point and checks the exact count. It also places lock changes just inside and just outside the last sample.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_BASE,
    ST_LINK,
    ST_CMN,
    ST_REFR,
    ST_HS,
    ST_CFGREQ,
    ST_CFGW,
    ST_CAL,
    ST_GEN,
    ST_CLO,
    ST_CHI,
    ST_LOCK
  } step_e;

endpackage

// File: rtl/physeq_lockwait.sv
module physeq_lockwait #(
  parameter int POLL_LIMIT = 10000,
  parameter int POLL_GAP   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic lock_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [PW-1:0] poll_q;
  logic [GW-1:0] gap_q;
  logic          sample;

  assign sample   = en_i && (gap_q == '0);
  assign hit_o    = sample && lock_i;
  assign expire_o = sample && !lock_i && (poll_q == PW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      poll_q <= '0;
      gap_q  <= '0;
    end else if (sample) begin
      if (!lock_i && !expire_o) begin
        poll_q <= poll_q + 1'b1;
        gap_q  <= GW'(POLL_GAP - 1);
      end
    end else begin
      gap_q <= gap_q - 1'b1;
    end
  end

endmodule

// File: rtl/physeq_regs.sv
module physeq_regs
  import physeq_pkg::*;
#(
  parameter int                 RST_W     = 20,
  parameter int                 GEN_W     = 2,
  parameter int                 GEN_CODE  = 2,
  parameter int                 CMN_BIT   = 1,
  parameter logic [RST_W-1:0]   BASE_SET  = 20'h0003D,
  parameter logic [RST_W-1:0]   LINK_SET  = 20'hF0000,
  parameter logic [1:0]         PHY_INIT  = 2'b10
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step_i,
  output logic [RST_W-1:0] rst_img_o,
  output logic [1:0]       phy_ctl_o,
  output logic [1:0]       cal_o,
  output logic [GEN_W-1:0] gen_o
);
  localparam int REFR_BIT = 1;
  localparam int HS_BIT   = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_img_o <= '0;
      phy_ctl_o <= PHY_INIT;
      cal_o     <= '0;
      gen_o     <= '0;
    end else begin
      unique case (step_i)
        ST_CLR:  rst_img_o <= '0;
        ST_BASE: rst_img_o <= rst_img_o | BASE_SET;
        ST_LINK: rst_img_o <= rst_img_o | LINK_SET;
        ST_CMN:  rst_img_o[CMN_BIT] <= 1'b1;
        ST_REFR: phy_ctl_o[REFR_BIT] <= 1'b0;
        ST_HS:   phy_ctl_o[HS_BIT] <= 1'b1;
        ST_CAL:  cal_o <= 2'b11;
        ST_GEN:  gen_o <= GEN_W'(GEN_CODE);
        ST_CLO:  rst_img_o[CMN_BIT] <= 1'b0;
        ST_CHI:  rst_img_o[CMN_BIT] <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
  import physeq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  input  logic  cfg_done_i,
  input  logic  cfg_err_i,
  input  logic  hit_i,
  input  logic  expire_i,
  output step_e step_o,
  output logic  lock_en_o,
  output logic  cfg_req_o,
  output logic  done_o,
  output logic  pass_o
);
  step_e state_q;
  logic  cfg_ok_q;

  assign step_o    = state_q;
  assign lock_en_o = (state_q == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cfg_req_o <= 1'b0;
      cfg_ok_q  <= 1'b0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CLR;
          done_o  <= 1'b0;
          pass_o  <= 1'b0;
        end
        ST_CLR:  state_q <= ST_BASE;
        ST_BASE: state_q <= ST_LINK;
        ST_LINK: state_q <= ST_CMN;
        ST_CMN:  state_q <= ST_REFR;
        ST_REFR: state_q <= ST_HS;
        ST_HS:   state_q <= ST_CFGREQ;
        ST_CFGREQ: begin
          cfg_req_o <= 1'b1;
          state_q   <= ST_CFGW;
        end
        ST_CFGW: if (cfg_done_i || cfg_err_i) begin
          cfg_req_o <= 1'b0;
          cfg_ok_q  <= !cfg_err_i;
          state_q   <= ST_CAL;
        end
        ST_CAL:  state_q <= ST_GEN;
        ST_GEN:  state_q <= ST_CLO;
        ST_CLO:  state_q <= ST_CHI;
        ST_CHI:  state_q <= ST_LOCK;
        ST_LOCK: if (hit_i || expire_i) begin
          done_o  <= 1'b1;
          pass_o  <= hit_i && cfg_ok_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import physeq_pkg::*;
#(
  parameter int               RST_W      = 20,
  parameter int               GEN_W      = 2,
  parameter int               GEN_CODE   = 2,
  parameter int               CMN_BIT    = 1,
  parameter logic [RST_W-1:0] BASE_SET   = 20'h0003D,
  parameter logic [RST_W-1:0] LINK_SET   = 20'hF0000,
  parameter logic [1:0]       PHY_INIT   = 2'b10,
  parameter int               POLL_LIMIT = 10000,
  parameter int               POLL_GAP   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cfg_done_i,
  input  logic             cfg_err_i,
  input  logic             pll_lock_i,
  output logic             cfg_req_o,
  output logic [RST_W-1:0] rst_img_o,
  output logic [1:0]       phy_ctl_o,
  output logic [1:0]       cal_o,
  output logic [GEN_W-1:0] gen_o,
  output logic             done_o,
  output logic             pass_o
);
  step_e step;
  logic  lock_en;
  logic  hit;
  logic  expire;

  physeq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_done_i (cfg_done_i),
    .cfg_err_i  (cfg_err_i),
    .hit_i      (hit),
    .expire_i   (expire),
    .step_o     (step),
    .lock_en_o  (lock_en),
    .cfg_req_o  (cfg_req_o),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

  physeq_regs #(
    .RST_W    (RST_W),
    .GEN_W    (GEN_W),
    .GEN_CODE (GEN_CODE),
    .CMN_BIT  (CMN_BIT),
    .BASE_SET (BASE_SET),
    .LINK_SET (LINK_SET),
    .PHY_INIT (PHY_INIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .rst_img_o (rst_img_o),
    .phy_ctl_o (phy_ctl_o),
    .cal_o     (cal_o),
    .gen_o     (gen_o)
  );

  physeq_lockwait #(
    .POLL_LIMIT (POLL_LIMIT),
    .POLL_GAP   (POLL_GAP)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .en_i     (lock_en),
    .lock_i   (pll_lock_i),
    .hit_o    (hit),
    .expire_o (expire)
  );

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int RST_W    = 20,
  parameter int GEN_W    = 2,
  parameter int GEN_CODE = 2,
  parameter int CMN_BIT  = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             cfg_done_i,
  input logic             cfg_err_i,
  input logic             cfg_req_o,
  input logic [RST_W-1:0] rst_img_o,
  input logic [1:0]       phy_ctl_o,
  input logic [1:0]       cal_o,
  input logic [GEN_W-1:0] gen_o,
  input logic             done_o,
  input logic             pass_o
);

  // R6
  cal_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_o == 2'b00) || (cal_o == 2'b11));

  // R6
  gen_value_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_o == '0) || (gen_o == GEN_W'(GEN_CODE)));

  // R9
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_o && !cfg_done_i && !cfg_err_i) |=> cfg_req_o);

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_o && (cfg_done_i || cfg_err_i)) |=> !cfg_req_o);

  // R7
  done_cmn_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> rst_img_o[CMN_BIT]);

  // R4
  hs_after_refr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_ctl_o[0]) |-> !phy_ctl_o[1]);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R5
  req_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req_o && done_o));

endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
  .RST_W    (RST_W),
  .GEN_W    (GEN_W),
  .GEN_CODE (GEN_CODE),
  .CMN_BIT  (CMN_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .cfg_done_i (cfg_done_i),
  .cfg_err_i  (cfg_err_i),
  .cfg_req_o  (cfg_req_o),
  .rst_img_o  (rst_img_o),
  .phy_ctl_o  (phy_ctl_o),
  .cal_o      (cal_o),
  .gen_o      (gen_o),
  .done_o     (done_o),
  .pass_o     (pass_o)
);

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5;
  localparam int GAP        = 3;
  localparam int CFG_DLY    = 3;

  typedef struct packed {
    logic [19:0] r;
    logic [1:0]  p;
    logic [1:0]  c;
    logic [1:0]  g;
    logic        q;
    logic        d;
    logic        s;
  } snap_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        cfg_done_i = 1'b0;
  logic        cfg_err_i = 1'b0;
  logic        pll_lock_i = 1'b0;
  logic        cfg_req_o;
  logic [19:0] rst_img_o;
  logic [1:0]  phy_ctl_o;
  logic [1:0]  cal_o;
  logic [1:0]  gen_o;
  logic        done_o;
  logic        pass_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;
  snap_t exp_q[$];
  string tag_q[$];
  snap_t last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_bringup_seq #(
    .POLL_LIMIT (LIMIT),
    .POLL_GAP   (GAP)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_done_i (cfg_done_i),
    .cfg_err_i  (cfg_err_i),
    .pll_lock_i (pll_lock_i),
    .cfg_req_o  (cfg_req_o),
    .rst_img_o  (rst_img_o),
    .phy_ctl_o  (phy_ctl_o),
    .cal_o      (cal_o),
    .gen_o      (gen_o),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

  function automatic snap_t observe();
    snap_t v;
    v.r = rst_img_o; v.p = phy_ctl_o; v.c = cal_o; v.g = gen_o;
    v.q = cfg_req_o; v.d = done_o; v.s = pass_o;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic push_exp(input snap_t v, input string tag);
    if (v !== last_exp) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
      last_exp = v;
    end
  endtask

  // Monitor: every change of the output vector must be the next expected item.
  initial begin
    snap_t prev;
    snap_t cur;
    snap_t e;
    string t;
    wait (mon_on);
    prev = observe();
    forever begin
      @(negedge clk);
      cur = observe();
      if (cur !== prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected change", 64'(cur), 64'(prev));
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cur === e, t, "step", 64'(cur), 64'(e));
        end
        prev = cur;
      end
    end
  end

  // lock_mode: 0 = lock high throughout, N>0 = raised N falling edges after
  // the final common-reset edge, -1 = never.
  task automatic run_seq(input bit err, input int lock_mode, input bit exp_pass,
                         input int exp_lat, input bit glitch);
    snap_t e;
    int    n;
    e = last_exp;
    e.d = 1'b0; e.s = 1'b0;     push_exp(e, "R2");
    e.r = 20'h00000;            push_exp(e, "R3");
    e.r = 20'h0003D;            push_exp(e, "R3");
    e.r = 20'hF003D;            push_exp(e, "R3");
    e.r = 20'hF003F;            push_exp(e, "R3");
    e.p[1] = 1'b0;              push_exp(e, "R4");
    e.p[0] = 1'b1;              push_exp(e, "R4");
    e.q = 1'b1;                 push_exp(e, "R5");
    e.q = 1'b0;                 push_exp(e, "R5");
    e.c = 2'b11;                push_exp(e, "R6");
    e.g = 2'd2;                 push_exp(e, "R6");
    e.r = 20'hF003D;            push_exp(e, "R7");
    e.r = 20'hF003F;            push_exp(e, "R7");
    e.d = 1'b1; e.s = exp_pass; push_exp(e, "R9");

    pll_lock_i = (lock_mode == 0);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (glitch) begin
      // R2: start during a run must not restart it
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (!cfg_req_o) @(negedge clk);
    repeat (CFG_DLY) @(negedge clk);
    if (err) cfg_err_i = 1'b1; else cfg_done_i = 1'b1;
    @(negedge clk);
    cfg_err_i = 1'b0; cfg_done_i = 1'b0;
    while (rst_img_o !== 20'hF003D) @(negedge clk);
    while (rst_img_o !== 20'hF003F) @(negedge clk);
    n = 0;
    while (!done_o) begin
      @(negedge clk);
      n++;
      if (n == lock_mode) pll_lock_i = 1'b1;
    end
    check(n == exp_lat, "R8", "lock latency", 64'(n), 64'(exp_lat));
    check(pass_o == exp_pass, "R9", "verdict", 64'(pass_o), 64'(exp_pass));
    pll_lock_i = 1'b0;
    repeat (6) @(negedge clk);
    check(done_o && (pass_o == exp_pass), "R9", "held verdict",
          64'({done_o, pass_o}), 64'({1'b1, exp_pass}));
    check(exp_q.size() == 0, "R3", "pending steps", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check(observe() === snap_t'({20'h0, 2'b10, 2'b00, 2'b00, 3'b000}), "R1",
          "reset outputs", 64'(observe()), 64'({20'h0, 2'b10, 6'b0, 1'b0}));
    rst = 1'b0;
    @(negedge clk);
    check(observe() === snap_t'({20'h0, 2'b10, 2'b00, 2'b00, 3'b000}), "R1",
          "after reset", 64'(observe()), 64'({20'h0, 2'b10, 6'b0, 1'b0}));
    last_exp = observe();
    mon_on = 1'b1;
    @(negedge clk);

    run_seq(1'b0,  0, 1'b1,  1, 1'b1);  // immediate lock, start glitch
    run_seq(1'b0,  5, 1'b1,  7, 1'b0);  // lock at third sample
    run_seq(1'b1,  0, 1'b0,  1, 1'b0);  // config error blocks pass
    run_seq(1'b0, 12, 1'b1, 13, 1'b0);  // lock just before last sample
    run_seq(1'b0, 13, 1'b0, 13, 1'b0);  // lock just after last sample
    run_seq(1'b0, -1, 1'b0, 13, 1'b0);  // never locks

    finish_run();
  end

endmodule